// File: doc/BRIEF.md
# Synchronous Burst Memory Command Decoder

This block sits in front of a synchronous burst static memory array. On every rising clock edge it samples three chip enables (two active low, one active high), two address strobes of unequal priority (a processor-side strobe and a controller-side strobe), a burst advance input and the write controls. The write controls are a global write, a byte-write enable and one enable per byte lane. It classifies the cycle and presents the result as a registered operation code, per-lane write strobes and pulses that load or step an external burst address counter.

The processor strobe always starts a read. It is blocked while the first active-low enable is high. The controller strobe starts a read or a write, depending on the write controls. Chip enables matter only in cycles where an accepted strobe is present. With no strobe, an open burst either moves on to the next address or holds the current one. A sleep input forces every cycle to deselect. After sleep is released, a recovery window of several cycles has to pass before any command is accepted. The array contents are not touched while this happens.

Top module: `burst_cmd_decoder`

## Requirements
- R1: While reset is low, after a clock edge: op_code is 0, lane_wr is all zero, ctr_load, ctr_step and dormant are 0, and no burst is open.
- R2: Operation codes are 0 idle/deselect, 1 read start, 2 write start, 3 read next, 4 write next, 5 read hold, 6 write hold. The outputs appear after the edge that samples the inputs. If the processor strobe is low, first enable is low, second enable is high and third enable is low, the result is code 1 with ctr_load high and lane_wr zero, whatever the write inputs are.
- R3: While cen_a_n is high, the processor strobe is ignored. The cycle decodes exactly as if that strobe were high.
- R4: In a cycle with an accepted strobe, if any enable is false the result is code 0 and any open burst is closed. Enables are not looked at in cycles without an accepted strobe.
- R5: The controller strobe, with the processor strobe not accepted and all enables true, gives code 2 if the write function is true and code 1 otherwise. ctr_load is high in both cases.
- R6: While wr_all_n is low, the write function is true and every lane_wr bit is set on a write code. The byte-write inputs have no effect.
- R7: While wr_all_n is high, the write function is true only when wr_en_n is low and at least one lane_en_n bit is low. lane_wr bit i is then the inverse of lane_en_n bit i. Otherwise the cycle is a read and lane_wr is zero.
- R8: With no strobe accepted and a burst open, adv_n low gives code 3 or 4 with ctr_step high. adv_n high gives code 5 or 6 with no pulse. Read or write follows the same cycle's write function.
- R9: With no strobe accepted and no burst open, the result is code 0.
- R10: On an edge where sleep_req is high, the result is code 0 and any open burst is closed. On the REC_CYCLES edges after the first edge with sleep_req low, the result is also code 0, even when strobes are present.
- R11: dormant is high after exactly the edges whose cycle was forced to code 0 by R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cen_a_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| cen_b | input | 1 | Second chip enable, active high |
| cen_c_n | input | 1 | Third chip enable, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low, read-only start |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_en_n | input | 1 | Byte-write enable, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| sleep_req | input | 1 | Sleep request, active high |
| op_code | output | 3 | Registered operation code |
| lane_wr | output | LANES | Registered per-lane write strobes |
| ctr_load | output | 1 | Burst counter load pulse |
| ctr_step | output | 1 | Burst counter advance pulse |
| dormant | output | 1 | Cycle was suppressed by sleep or recovery |

## Verification
The hidden state is the open-burst flag and the sleep recovery counter. If the open-burst flag is wrong, the next strobe-free cycle shows it at once: a continue or hold code appears where idle was expected, or idle appears where a continue was expected. If the recovery counter is wrong, the first strobe inside or just past the window shows it, because that strobe is accepted one cycle too early or too late. dormant shows the same error in the same cycle. The bench drives long random runs with sleep pulses and with back-to-back strobes, so both kinds of error reach the ports within a few cycles of being created.

// File: rtl/burst_cmd_pkg.sv
// Shared definitions for the burst command decoder.
// Assumes: operation codes are consumed by an array-access stage one
// cycle after the sampling edge.
package burst_cmd_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE     = 3'd0,
        OP_RD_START = 3'd1,
        OP_WR_START = 3'd2,
        OP_RD_NEXT  = 3'd3,
        OP_WR_NEXT  = 3'd4,
        OP_RD_HOLD  = 3'd5,
        OP_WR_HOLD  = 3'd6
    } op_e;

    // Pick the read or write flavour of an operation pair.
    function automatic op_e pick_rw(input logic is_wr, input op_e rd, input op_e wr);
        return is_wr ? wr : rd;
    endfunction

endpackage

// File: rtl/bcd_sleep_guard.sv
// Sleep guard: raises guard while sleep is sampled high and for
// REC_CYCLES edges after it is released.
// Assumes: sleep_req meets setup to clk (it is used as a synchronous input).
module bcd_sleep_guard #(
    parameter int REC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic guard
);
    localparam int CW = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYCLES);

    logic [CW-1:0] rec_cnt;

    // Recovery counter: reload while asleep, count down afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt <= '0;
        end else if (sleep_req) begin
            rec_cnt <= REC_LOAD;
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    // Guard is live in the sampling cycle itself.
    always_comb guard = sleep_req || (rec_cnt != '0);

endmodule

// File: rtl/bcd_lane_write.sv
// Lane write decode: combines global write, byte-write enable and the
// per-lane enables into a write function and a lane mask.
// Assumes: all inputs active low.
module bcd_lane_write #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_en_n,
    input  logic [LANES-1:0] lane_en_n,
    output logic [LANES-1:0] lane_mask,
    output logic             write_fn
);
    logic [LANES-1:0] sel;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Per-lane select: global write wins, else byte enable qualified.
            always_comb sel[g] = !wr_all_n || (!wr_en_n && !lane_en_n[g]);
        end
    endgenerate

    // Write function is true when any lane is selected.
    always_comb begin
        lane_mask = sel;
        write_fn  = |sel;
    end

endmodule

// File: rtl/bcd_start_qual.sv
// Strobe qualification: resolves strobe priority and enable sampling.
// Assumes: strobes and enables are active as named; enables are only
// meaningful when an accepted strobe is present.
module bcd_start_qual (
    input  logic strb_cpu_n,
    input  logic strb_ctl_n,
    input  logic cen_a_n,
    input  logic cen_b,
    input  logic cen_c_n,
    output logic start_go,
    output logic start_rd_only,
    output logic start_kill
);
    logic cpu_take;
    logic ctl_take;
    logic en_ok;

    // Strobe priority and enable check.
    always_comb begin
        cpu_take      = !strb_cpu_n && !cen_a_n;
        ctl_take      = !cpu_take && !strb_ctl_n;
        en_ok         = !cen_a_n && cen_b && !cen_c_n;
        start_go      = (cpu_take || ctl_take) && en_ok;
        start_kill    = (cpu_take || ctl_take) && !en_ok;
        start_rd_only = cpu_take;
    end

endmodule

// File: rtl/burst_cmd_decoder.sv
// Burst command decoder top: classifies every sampled cycle and
// registers the operation code, lane strobes and counter pulses.
// Assumes: synchronous active-low reset; outputs valid after the edge
// that samples the inputs.
module burst_cmd_decoder
    import burst_cmd_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int REC_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen_a_n,
    input  logic             cen_b,
    input  logic             cen_c_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_en_n,
    input  logic [LANES-1:0] lane_en_n,
    input  logic             sleep_req,
    output logic [OP_W-1:0]  op_code,
    output logic [LANES-1:0] lane_wr,
    output logic             ctr_load,
    output logic             ctr_step,
    output logic             dormant
);
    logic             guard_w;
    logic [LANES-1:0] mask_w;
    logic             wfn_w;
    logic             go_w, rd_only_w, kill_w;
    logic             burst_q, burst_d;
    op_e              op_d;
    logic             load_d, step_d, is_wr_d;

    bcd_sleep_guard #(.REC_CYCLES(REC_CYCLES)) i_guard (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .guard(guard_w)
    );

    bcd_lane_write #(.LANES(LANES)) i_lanes (
        .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .lane_en_n(lane_en_n),
        .lane_mask(mask_w), .write_fn(wfn_w)
    );

    bcd_start_qual i_qual (
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .cen_a_n(cen_a_n), .cen_b(cen_b), .cen_c_n(cen_c_n),
        .start_go(go_w), .start_rd_only(rd_only_w), .start_kill(kill_w)
    );

    // Next command, pulses and burst-open flag for this cycle.
    always_comb begin
        op_d    = OP_IDLE;
        load_d  = 1'b0;
        step_d  = 1'b0;
        burst_d = burst_q;
        if (guard_w) begin
            burst_d = 1'b0;
        end else if (go_w) begin
            op_d    = pick_rw(wfn_w && !rd_only_w, OP_RD_START, OP_WR_START);
            load_d  = 1'b1;
            burst_d = 1'b1;
        end else if (kill_w) begin
            burst_d = 1'b0;
        end else if (burst_q) begin
            if (!adv_n) begin
                op_d   = pick_rw(wfn_w, OP_RD_NEXT, OP_WR_NEXT);
                step_d = 1'b1;
            end else begin
                op_d   = pick_rw(wfn_w, OP_RD_HOLD, OP_WR_HOLD);
            end
        end
        is_wr_d = (op_d == OP_WR_START) || (op_d == OP_WR_NEXT) || (op_d == OP_WR_HOLD);
    end

    // Output and state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_code  <= OP_IDLE;
            lane_wr  <= '0;
            ctr_load <= 1'b0;
            ctr_step <= 1'b0;
            dormant  <= 1'b0;
            burst_q  <= 1'b0;
        end else begin
            op_code  <= op_d;
            lane_wr  <= is_wr_d ? mask_w : '0;
            ctr_load <= load_d;
            ctr_step <= step_d;
            dormant  <= guard_w;
            burst_q  <= burst_d;
        end
    end

endmodule

// File: rtl/bcd_checker.sv
// Property checker for the burst command decoder, bound to the top.
// Assumes: guard is the internal sleep/recovery gate of the top.
module bcd_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cen_a_n,
    input logic             cen_b,
    input logic             cen_c_n,
    input logic             strb_cpu_n,
    input logic             strb_ctl_n,
    input logic             wr_all_n,
    input logic             sleep_req,
    input logic             guard,
    input logic [2:0]       op_code,
    input logic [LANES-1:0] lane_wr,
    input logic             ctr_load,
    input logic             ctr_step,
    input logic             dormant
);
    // R2
    cpu_read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard && !strb_cpu_n && !cen_a_n && cen_b && !cen_c_n)
        |=> (op_code == 3'd1 && lane_wr == '0 && ctr_load));

    // R4
    enable_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard && strb_cpu_n && !strb_ctl_n && !cen_b)
        |=> (op_code == 3'd0 && !ctr_load));

    // R6
    global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard && strb_cpu_n && !strb_ctl_n && !cen_a_n && cen_b && !cen_c_n && !wr_all_n)
        |=> (op_code == 3'd2 && lane_wr == {LANES{1'b1}}));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd5 || op_code == 3'd6) |-> (!ctr_step && !ctr_load));

    // R10
    sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (op_code == 3'd0 && !ctr_load && !ctr_step && dormant));

    // R11
    dormant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dormant |-> (op_code == 3'd0 && lane_wr == '0));

endmodule

bind burst_cmd_decoder bcd_checker #(.LANES(LANES)) i_bcd_checker (
    .clk(clk), .rst_n(rst_n), .cen_a_n(cen_a_n), .cen_b(cen_b),
    .cen_c_n(cen_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .wr_all_n(wr_all_n), .sleep_req(sleep_req), .guard(guard_w),
    .op_code(op_code), .lane_wr(lane_wr), .ctr_load(ctr_load),
    .ctr_step(ctr_step), .dormant(dormant)
);

// File: tb/test_burst_cmd_decoder.sv
`timescale 1ns/1ps
module test_burst_cmd_decoder;
    localparam int LANES = 4;
    localparam int REC   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cen_a_n = 1'b1, cen_b = 1'b1, cen_c_n = 1'b0;
    logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic wr_all_n = 1'b1, wr_en_n = 1'b1;
    logic [LANES-1:0] lane_en_n = '1;
    logic sleep_req = 1'b0;
    logic [2:0] op_code;
    logic [LANES-1:0] lane_wr;
    logic ctr_load, ctr_step, dormant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state.
    bit m_burst = 1'b0;
    int m_rec = 0;

    always #2 clk = ~clk;

    burst_cmd_decoder #(.LANES(LANES), .REC_CYCLES(REC)) i_burst_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cen_a_n(cen_a_n), .cen_b(cen_b),
        .cen_c_n(cen_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_en_n(wr_en_n),
        .lane_en_n(lane_en_n), .sleep_req(sleep_req), .op_code(op_code),
        .lane_wr(lane_wr), .ctr_load(ctr_load), .ctr_step(ctr_step),
        .dormant(dormant)
    );

    function automatic bit wfn_f();
        return !wr_all_n || (!wr_en_n && (lane_en_n != '1));
    endfunction

    function automatic logic [LANES-1:0] mask_f();
        if (!wr_all_n) return '1;
        if (!wr_en_n) return ~lane_en_n;
        return '0;
    endfunction

    // One cycle: inputs already driven; compute expectation, clock, compare.
    task automatic step_check();
        logic [2:0] e_op = 3'd0;
        bit e_load = 0, e_step = 0, e_dorm;
        string tag;
        bit gate = sleep_req || (m_rec != 0);
        bit cpu_take = !strb_cpu_n && !cen_a_n;
        bit ctl_take = !cpu_take && !strb_ctl_n;
        bit en_ok = !cen_a_n && cen_b && !cen_c_n;
        bit w = wfn_f();
        bit blocked = !strb_cpu_n && cen_a_n;
        logic [LANES-1:0] e_lanes;
        e_dorm = gate;
        if (gate) begin
            tag = "R10"; m_burst = 0;
        end else if (cpu_take && en_ok) begin
            e_op = 3'd1; e_load = 1; m_burst = 1; tag = "R2";
        end else if ((cpu_take || ctl_take) && !en_ok) begin
            m_burst = 0; tag = blocked ? "R3" : "R4";
        end else if (ctl_take) begin
            e_op = w ? 3'd2 : 3'd1; e_load = 1; m_burst = 1;
            tag = blocked ? "R3" : (!wr_all_n ? "R6" : (w ? "R7" : "R5"));
        end else if (m_burst) begin
            if (!adv_n) begin e_op = w ? 3'd4 : 3'd3; e_step = 1; end
            else e_op = w ? 3'd6 : 3'd5;
            tag = blocked ? "R3" : "R8";
        end else begin
            tag = blocked ? "R3" : "R9";
        end
        e_lanes = (e_op == 3'd2 || e_op == 3'd4 || e_op == 3'd6) ? mask_f() : '0;
        if (sleep_req) m_rec = REC; else if (m_rec > 0) m_rec--;
        @(posedge clk);
        #1;
        checks++;
        if (op_code !== e_op || lane_wr !== e_lanes || ctr_load !== e_load
            || ctr_step !== e_step) begin
            errors++;
            $display("FAIL %s: op=%0d lanes=%b load=%b step=%b expected op=%0d lanes=%b load=%b step=%b",
                     tag, op_code, lane_wr, ctr_load, ctr_step, e_op, e_lanes, e_load, e_step);
        end
        checks++;
        if (dormant !== e_dorm) begin
            errors++;
            $display("FAIL R11: dormant=%b expected %b", dormant, e_dorm);
        end
    endtask

    task automatic idle_in();
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1; cen_a_n = 0; cen_b = 1; cen_c_n = 0;
        wr_all_n = 1; wr_en_n = 1; lane_en_n = '1; sleep_req = 0;
    endtask

    task automatic ctl_start(input bit ga, input bit be, input logic [LANES-1:0] le);
        @(negedge clk);
        idle_in(); strb_ctl_n = 0; wr_all_n = ga; wr_en_n = be; lane_en_n = le;
        step_check();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        idle_in();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        checks++;
        if (op_code !== 3'd0 || lane_wr !== '0 || ctr_load !== 0 || ctr_step !== 0 || dormant !== 0) begin
            errors++;
            $display("FAIL R1: op=%0d lanes=%b load=%b step=%b dorm=%b expected all zero",
                     op_code, lane_wr, ctr_load, ctr_step, dormant);
        end
        @(negedge clk); rst_n = 1;

        // R6: global write overrides byte controls
        ctl_start(0, 1, '1);
        // R7: byte-write enable high with lanes low -> read
        ctl_start(1, 1, 4'b0000);
        // R7: all lanes high -> read
        ctl_start(1, 0, 4'b1111);
        // R7: selected lanes only
        ctl_start(1, 0, 4'b1010);
        // R8: continue then hold
        @(negedge clk); idle_in(); adv_n = 0; step_check();
        @(negedge clk); idle_in(); adv_n = 1; step_check();
        // R2: processor start ignores global write
        @(negedge clk); idle_in(); strb_cpu_n = 0; wr_all_n = 0; step_check();
        // R3: blocked processor strobe with burst open -> continue rules
        @(negedge clk); idle_in(); strb_cpu_n = 0; cen_a_n = 1; adv_n = 0; step_check();
        // R4: enables false on strobe cycle closes burst; R9 afterwards
        @(negedge clk); idle_in(); strb_ctl_n = 0; cen_c_n = 1; step_check();
        @(negedge clk); idle_in(); adv_n = 0; step_check();
        // R10: sleep then strobes throughout recovery
        @(negedge clk); idle_in(); sleep_req = 1; strb_ctl_n = 0; step_check();
        @(negedge clk); idle_in(); sleep_req = 1; strb_cpu_n = 0; step_check();
        for (int k = 0; k < REC + 2; k++) begin
            @(negedge clk); idle_in(); strb_ctl_n = 0; wr_all_n = 0; step_check();
        end

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            strb_cpu_n = ($urandom_range(99) >= 25);
            strb_ctl_n = ($urandom_range(99) >= 30);
            cen_a_n    = ($urandom_range(99) < 20);
            cen_b      = ($urandom_range(99) >= 15);
            cen_c_n    = ($urandom_range(99) < 15);
            adv_n      = $urandom_range(1);
            wr_all_n   = ($urandom_range(99) >= 20);
            wr_en_n    = $urandom_range(1);
            lane_en_n  = LANES'($urandom);
            if (sleep_req) sleep_req = ($urandom_range(99) < 60);
            else sleep_req = ($urandom_range(99) < 3);
            step_check();
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule